// File: doc/BRIEF.md
# Memory Error First/Next Log Unit

This unit sits behind an ECC checker and keeps a record of the memory errors it reports. Two kinds of event arrive. A correctable event carries the 4 KiB page it hit and a syndrome. An uncorrectable event carries the page only. For each kind the unit holds a "first" status bit and a "next" status bit. The first bit marks that an error is logged. The next bit marks that another error of the same kind came in while the log was still occupied. In that case the extra error's address is lost.

The unit keeps a correctable address log, a syndrome log and an uncorrectable address log. Each log always holds the oldest error that software has not yet acknowledged. A channel number is derived from the logged syndrome. Software reads the status and log outputs, then acknowledges by writing ones to the status bits. A pending flag stays high while any status bit is set, for use as an interrupt source.

Top module: `mem_err_log`

## Requirements
- R1: After reset both status bytes, all logs, the channel and pending are zero. In each status byte bit 0 means correctable and bit 1 means uncorrectable; bits 7:2 always read zero.
- R2: A correctable event while first bit 0 is clear has these effects on the next cycle: first bit 0 is set, the correctable address log becomes the page in bits 27:6 with bits 31:28 and 5:0 zero, and the syndrome log takes the event's syndrome.
- R3: An event of a kind whose first bit is already set sets only that kind's next bit. The logs for that kind keep their contents.
- R4: A one on clr_first[k] or clr_next[k] clears bit k of that status byte on the next cycle. A zero leaves the bit unchanged.
- R5: If an event and a clear for the bit that event would set arrive in the same cycle, the event wins. If a clear of a first bit meets an event of that kind while the first bit is set, the first bit clears and the next bit sets.
- R6: ce_chan is 0 when the logged syndrome's upper byte is zero, else 1 when its lower byte is zero. Otherwise it is 0 if bits 15:12 or bits 11:8 are zero, and 1 in the remaining cases.
- R7: pending is high exactly when any of bits 1:0 of either status byte is set.
- R8: The two error kinds are tracked independently. An uncorrectable event loads only the uncorrectable address log (same field layout as R2) and first bit 1. A correctable event never touches it. Simultaneous events of both kinds are both recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error event |
| ue_evt | input | 1 | Uncorrectable error event |
| evt_page | input | 22 | 4 KiB page of the event (address bits 33:12) |
| evt_syn | input | 16 | Syndrome of a correctable event |
| clr_first | input | 2 | Write-one-to-clear strobe for first status bits 1:0 |
| clr_next | input | 2 | Write-one-to-clear strobe for next status bits 1:0 |
| first_stat | output | 8 | First-error status byte |
| next_stat | output | 8 | Next-error status byte |
| ce_addr_log | output | 32 | Correctable error address log |
| ce_syn_log | output | 16 | Correctable error syndrome log |
| ue_addr_log | output | 32 | Uncorrectable error address log |
| ce_chan | output | 1 | Channel derived from the logged syndrome |
| pending | output | 1 | Any status bit set |

## Verification
A single correctable event and a single uncorrectable event show that each kind reaches only its own log. Back-to-back events of one kind separate the first bit from the next bit, and show that the log keeps the older address. Clears that collide with events tell the event-wins rule apart from a plain clear. Syndromes with a zero upper byte, a zero lower byte, one zero upper nibble and no zero part cover each branch of the channel rule. A long pseudo-random stretch of mixed events and clears is then compared against the reference model on every cycle.

// File: rtl/mem_err_log_pkg.sv
package mem_err_log_pkg;
   localparam int NKIND  = 2;
   localparam int CE_IDX = 0;
   localparam int UE_IDX = 1;
endpackage

// File: rtl/mel_kind_track.sv
module mel_kind_track (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr_first,
   input  logic clr_next,
   output logic first_q,
   output logic next_q,
   output logic load
);
   logic first_d, next_d;

   // a log load happens only when the slot is free
   assign load = evt & ~first_q;

   always_comb begin
      first_d = first_q;
      if (load)           first_d = 1'b1;
      else if (clr_first) first_d = 1'b0;
      next_d = next_q;
      if (evt && first_q) next_d = 1'b1;
      else if (clr_next)  next_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         next_q  <= 1'b0;
      end else begin
         first_q <= first_d;
         next_q  <= next_d;
      end
   end
endmodule

// File: rtl/mel_log_reg.sv
module mel_log_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/mel_chan_decode.sv
module mel_chan_decode #(
   parameter int SYN_W = 16
) (
   input  logic [SYN_W-1:0] syn,
   output logic             chan
);
   localparam int HALF = SYN_W / 2;
   localparam int QTR  = SYN_W / 4;

   logic up_zero, lo_zero, q_top_zero, q_next_zero;

   assign up_zero     = (syn[SYN_W-1:HALF] == '0);
   assign lo_zero     = (syn[HALF-1:0] == '0);
   assign q_top_zero  = (syn[SYN_W-1:SYN_W-QTR] == '0);
   assign q_next_zero = (syn[SYN_W-QTR-1:HALF] == '0);

   always_comb begin
      if (up_zero)                         chan = 1'b0;
      else if (lo_zero)                    chan = 1'b1;
      else if (q_top_zero || q_next_zero)  chan = 1'b0;
      else                                 chan = 1'b1;
   end
endmodule

// File: rtl/mem_err_log.sv
module mem_err_log #(
   parameter int PAGE_W   = 22,
   parameter int SYN_W    = 16,
   parameter int LOG_W    = 32,
   parameter int PAGE_LSB = 6,
   parameter int STAT_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_evt,
   input  logic                ue_evt,
   input  logic [PAGE_W-1:0]   evt_page,
   input  logic [SYN_W-1:0]    evt_syn,
   input  logic [1:0]          clr_first,
   input  logic [1:0]          clr_next,
   output logic [STAT_W-1:0]   first_stat,
   output logic [STAT_W-1:0]   next_stat,
   output logic [LOG_W-1:0]    ce_addr_log,
   output logic [SYN_W-1:0]    ce_syn_log,
   output logic [LOG_W-1:0]    ue_addr_log,
   output logic                ce_chan,
   output logic                pending
);
   import mem_err_log_pkg::*;

   localparam int HI_PAD = LOG_W - PAGE_LSB - PAGE_W;

   if (HI_PAD < 1 || PAGE_LSB < 1) begin : g_bad_layout
      $error("mem_err_log: page field does not fit the log word");
   end
   if (SYN_W % 4 != 0 || SYN_W < 4) begin : g_bad_syn
      $error("mem_err_log: syndrome width must be a multiple of four");
   end
   if (STAT_W < NKIND + 1) begin : g_bad_stat
      $error("mem_err_log: status byte too narrow");
   end

   logic [NKIND-1:0] evt_v, first_v, next_v, load_v;
   logic [PAGE_W-1:0] page_q [NKIND];

   assign evt_v[CE_IDX] = ce_evt;
   assign evt_v[UE_IDX] = ue_evt;

   for (genvar k = 0; k < NKIND; k++) begin : g_kind
      mel_kind_track u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_v[k]),
         .clr_first(clr_first[k]),
         .clr_next (clr_next[k]),
         .first_q  (first_v[k]),
         .next_q   (next_v[k]),
         .load     (load_v[k])
      );
      mel_log_reg #(.W(PAGE_W)) u_page (
         .clk  (clk),
         .rst_n(rst_n),
         .load (load_v[k]),
         .d    (evt_page),
         .q    (page_q[k])
      );
   end

   mel_log_reg #(.W(SYN_W)) u_syn (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_v[CE_IDX]),
      .d    (evt_syn),
      .q    (ce_syn_log)
   );

   mel_chan_decode #(.SYN_W(SYN_W)) u_chan (
      .syn (ce_syn_log),
      .chan(ce_chan)
   );

   assign first_stat  = {{(STAT_W-NKIND){1'b0}}, first_v};
   assign next_stat   = {{(STAT_W-NKIND){1'b0}}, next_v};
   assign ce_addr_log = {{HI_PAD{1'b0}}, page_q[CE_IDX], {PAGE_LSB{1'b0}}};
   assign ue_addr_log = {{HI_PAD{1'b0}}, page_q[UE_IDX], {PAGE_LSB{1'b0}}};
   assign pending     = |{first_v, next_v};
endmodule

// File: rtl/mem_err_log_chk.sv
module mem_err_log_chk #(
   parameter int PAGE_W   = 22,
   parameter int SYN_W    = 16,
   parameter int LOG_W    = 32,
   parameter int PAGE_LSB = 6,
   parameter int STAT_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_evt,
   input logic              ue_evt,
   input logic [PAGE_W-1:0] evt_page,
   input logic [SYN_W-1:0]  evt_syn,
   input logic [1:0]        clr_first,
   input logic [1:0]        clr_next,
   input logic [STAT_W-1:0] first_stat,
   input logic [STAT_W-1:0] next_stat,
   input logic [LOG_W-1:0]  ce_addr_log,
   input logic [SYN_W-1:0]  ce_syn_log,
   input logic [LOG_W-1:0]  ue_addr_log,
   input logic              ce_chan,
   input logic              pending
);
   // R2
   ce_first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && !first_stat[0]) |=> (first_stat[0] && ce_syn_log == $past(evt_syn)));
   // R3
   ce_log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_stat[0] |=> ($stable(ce_addr_log) && $stable(ce_syn_log)));
   // R3
   ue_next_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && first_stat[1]) |=> (next_stat[1] && $stable(ue_addr_log)));
   // R4
   clr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_next[0] && !ce_evt) |=> !next_stat[0]);
   // R5
   evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && clr_first[0] && !first_stat[0]) |=> first_stat[0]);
   // R7
   pending_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt || ue_evt) |=> pending);
   // R8
   ue_log_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ue_evt |=> $stable(ue_addr_log));
   // R1
   upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (first_stat[STAT_W-1:2] == '0) && (next_stat[STAT_W-1:2] == '0));
endmodule

bind mem_err_log mem_err_log_chk #(
   .PAGE_W(PAGE_W), .SYN_W(SYN_W), .LOG_W(LOG_W),
   .PAGE_LSB(PAGE_LSB), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/mem_err_log_test.sv
module mem_err_log_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_evt = 0, ue_evt = 0;
   logic [21:0] evt_page = '0;
   logic [15:0] evt_syn = '0;
   logic [1:0]  clr_first = '0, clr_next = '0;
   logic [7:0]  first_stat, next_stat;
   logic [31:0] ce_addr_log, ue_addr_log;
   logic [15:0] ce_syn_log;
   logic        ce_chan, pending;

   int tests = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_err_log uut (.*);

   // reference model state
   bit [1:0]  m_first, m_next;
   bit [21:0] m_cepg, m_uepg;
   bit [15:0] m_syn;

   function automatic bit chan_of(bit [15:0] s);
      if (s[15:8] == 0) return 0;
      if (s[7:0] == 0) return 1;
      if (s[15:12] == 0 || s[11:8] == 0) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      bit [1:0] ev;
      ev = {ue_evt, ce_evt};
      if (!rst_n) begin
         m_first = 0; m_next = 0; m_cepg = 0; m_uepg = 0; m_syn = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            if (ev[k] && !m_first[k]) begin
               m_first[k] = 1;
               if (k == 0) begin m_cepg = evt_page; m_syn = evt_syn; end
               else m_uepg = evt_page;
            end else begin
               if (ev[k]) m_next[k] = 1;
               else if (clr_next[k]) m_next[k] = 0;
               if (clr_first[k]) m_first[k] = 0;
               continue;
            end
            if (clr_next[k]) m_next[k] = 0;
         end
      end
   end

   task automatic chk(string tag, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " R1 first"}, first_stat, {6'b0, m_first});
      chk({tag, " R3 next"}, next_stat, {6'b0, m_next});
      chk({tag, " R2 ce_addr"}, ce_addr_log, {4'b0, m_cepg, 6'b0});
      chk({tag, " R2 ce_syn"}, ce_syn_log, m_syn);
      chk({tag, " R8 ue_addr"}, ue_addr_log, {4'b0, m_uepg, 6'b0});
      chk({tag, " R6 chan"}, ce_chan, chan_of(m_syn));
      chk({tag, " R7 pending"}, pending, |{m_first, m_next});
   endtask

   always @(negedge clk) if (rst_n && !done) check_all("cyc");

   task automatic drive(bit ce, bit ue, bit [21:0] pg, bit [15:0] sy,
                        bit [1:0] cf, bit [1:0] cn);
      @(posedge clk); #1;
      ce_evt = ce; ue_evt = ue; evt_page = pg; evt_syn = sy;
      clr_first = cf; clr_next = cn;
      @(posedge clk); #1;
      ce_evt = 0; ue_evt = 0; clr_first = 0; clr_next = 0;
   endtask

   task automatic try_chan(bit [15:0] sy, bit exp);
      drive(0, 0, 0, 0, 2'b01, 2'b01);
      drive(1, 0, 22'h1234, sy, 0, 0);
      @(negedge clk);
      chk("R6 channel", ce_chan, exp);
   endtask

   initial begin
      bit [31:0] lfsr;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1 reset first", first_stat, 0);
      chk("R1 reset pending", pending, 0);
      chk("R1 reset ue log", ue_addr_log, 0);
      // R2 first correctable
      drive(1, 0, 22'h3ABCDE, 16'h00A5, 0, 0);
      @(negedge clk);
      chk("R2 ce addr", ce_addr_log, 32'h0EAF3780);
      chk("R2 first bit0", first_stat, 8'h01);
      chk("R8 ue log untouched", ue_addr_log, 0);
      // R3 overflow
      drive(1, 0, 22'h000111, 16'hFFFF, 0, 0);
      @(negedge clk);
      chk("R3 next bit0", next_stat, 8'h01);
      chk("R3 addr kept", ce_addr_log, 32'h0EAF3780);
      // R4 clear next only, zero on first leaves it
      drive(0, 0, 0, 0, 2'b00, 2'b01);
      @(negedge clk);
      chk("R4 next cleared", next_stat, 0);
      chk("R4 first kept", first_stat, 8'h01);
      // R8 uncorrectable, simultaneous
      drive(1, 1, 22'h2AAAAA, 16'h1111, 0, 0);
      @(negedge clk);
      chk("R8 ue first", first_stat, 8'h03);
      chk("R8 ue addr", ue_addr_log, {4'b0, 22'h2AAAAA, 6'b0});
      chk("R8 ce overflow", next_stat, 8'h01);
      // R5 clear first meets event while set
      drive(1, 0, 22'h5, 16'h2222, 2'b01, 0);
      @(negedge clk);
      chk("R5 first cleared", first_stat[0], 0);
      chk("R5 next set", next_stat[0], 1);
      // R5 event with clear of a free first bit
      drive(1, 0, 22'h7, 16'h0F00, 2'b01, 2'b01);
      @(negedge clk);
      chk("R5 event wins", first_stat[0], 1);
      chk("R5 load on win", ce_addr_log, {4'b0, 22'h7, 6'b0});
      // R6 channel branches
      try_chan(16'h00C3, 0);
      try_chan(16'h3C00, 1);
      try_chan(16'h0512, 0);
      try_chan(16'h5012, 0);
      try_chan(16'h5A12, 1);
      // R4 full clear
      drive(0, 0, 0, 0, 2'b11, 2'b11);
      @(negedge clk);
      chk("R4 all clear", {first_stat, next_stat}, 0);
      chk("R7 pending low", pending, 0);
      // mixed traffic against model
      lfsr = 32'hACE1_2357;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         @(posedge clk); #1;
         ce_evt = lfsr[0] & lfsr[5];
         ue_evt = lfsr[1] & lfsr[6] & lfsr[9];
         evt_page = lfsr[31:10];
         evt_syn = lfsr[3] ? {lfsr[15:8], 8'h00} : lfsr[27:12];
         clr_first = lfsr[7:6] & {2{lfsr[2]}};
         clr_next = lfsr[9:8] & {2{lfsr[4]}};
      end
      @(posedge clk); #1;
      ce_evt = 0; ue_evt = 0; clr_first = 0; clr_next = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule